// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger

This block watches every local bus transfer of a processor core and compares three of its properties with programmed breakpoint conditions. The properties are the program counter, the data address and the data value. There are two trigger levels. A first-level condition arms the trigger. An optional second-level condition then completes it. When the full condition is met, the block gives a configurable response. A one-cycle trace pulse is always issued. Depending on the response field, the block also raises a halt request or a debug interrupt request.

Software programs the block through a simple register write port. There are five registers: the trigger definition word, the address low bound, the address high bound, the data comparison value and the PC comparison value. The definition word is read back on a dedicated output. A two-bit status output reports how far the trigger has progressed.

Each level can use any mix of three conditions: a PC comparison, an address comparison and a data comparison. All enabled conditions of a level must match in the same transfer. The data comparison considers only the byte lanes that the transfer actually drives. Each of the three comparisons can be inverted.

Top module: `dbg_trig_unit`

## Requirements
- R1: The definition register holds the first-level fields in [15:0] and the second-level fields in [31:16]; bits [15:14] always read as zero on `tdef_rd`, and every other bit reads back as written. Within each 16-bit half, the field positions relative to bit 0 of the half are:
  - bit 13: level enable
  - bits 12..6: data enables for, in order, longword, lower word, upper word, byte lane 3, byte lane 2, byte lane 1, byte lane 0
  - bit 5: data invert
  - bit 4: address invert
  - bit 3: address range mode
  - bit 2: address low-only mode
  - bit 1: PC enable
  - bit 0: PC invert
- R2: Response field [31:30]: 01 raises `halt_req`, 10 raises `irq_req`, and 00 and 11 raise neither; `trace_pulse` is high for exactly one cycle on every completed trigger, whatever the response code.
- R3: A level whose enable bit (13 or 29) is clear never matches; with both enables clear the status stays idle and no response is ever given.
- R4: A write to the definition register (`cfg_sel` 0) clears the trigger status; the status becomes 01 (waiting for level 1) if the new bit 13 is set, and 00 (idle) otherwise.
- R5: The data condition uses the data-enable bit that fits the access. `bus_size` encodes 0 as byte, 1 as word, and 2 or 3 as longword.
  - A byte access at address offset k uses the enable for byte lane k.
  - A word access uses the lower-word enable when address bit 1 is 0, and the upper-word enable when address bit 1 is 1.
  - A longword access uses the longword enable.
  - If the fitting enable is clear, the data condition fails. If all seven enables are clear, the data condition is off.
- R6: The data comparison covers only the driven byte lanes. Byte lane k is `bus_data[8k+7:8k]`. The lanes are: k for a byte access, 0..1 or 2..3 for a word access, and all four for a longword access. Differences in other lanes are ignored. With the data-invert bit set, a difference in a driven lane matches and equality does not.
- R7: The address condition is on when any of bits 4, 3 and 2 of the level is set.
  - Range mode matches `cfg_lo <= addr <= cfg_hi`, both bounds inclusive.
  - Otherwise the address must equal the low bound.
  - The invert bit flips the result.
- R8: With the PC-enable bit set, the PC condition matches when `bus_pc` equals the PC value register, or, with the PC-invert bit set, when it differs.
- R9: In status 01, a first-level match moves the status to 10 (level 1 hit) when any of bits [29:16] is set. In status 10, only a second-level match completes the trigger and sets status 11. Second-level matches in status 01 have no effect.
- R10: When bits [29:16] are all zero, a first-level match in status 01 completes the trigger directly: status 11, trace pulse, response.
- R11: `halt_req` or `irq_req` stays asserted, and status stays 11, until the next write to the definition register. Writes to the other registers leave them unchanged.
- R12: Transfers with `bus_valid` low are ignored. Status and the trace pulse change on the clock edge that samples a matching valid transfer.
- R13: All enabled conditions of a level must match in the same transfer. A level that is enabled but has no condition enabled never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 definition, 1 address low, 2 address high, 3 data value, 4 PC value |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus transfer is present this cycle |
| bus_pc | input | 32 | PC of the transfer |
| bus_addr | input | 32 | Data address of the transfer |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2/3 longword |
| bus_data | input | 32 | Data value on the byte lanes |
| tdef_rd | output | 32 | Definition register readback |
| trig_state | output | 2 | 00 idle, 01 waiting for level 1, 10 level 1 hit, 11 complete |
| trace_pulse | output | 1 | One-cycle pulse on a completed trigger |
| halt_req | output | 1 | Held halt request |
| irq_req | output | 1 | Held debug interrupt request |

## Verification
A register write or a bus transfer is sampled on one rising edge. Its effect on `trig_state`, `tdef_rd`, `trace_pulse`, `halt_req` and `irq_req` appears right after that same edge: one cycle of latency, with no extra pipeline stage. The bench drives each stimulus on a falling edge and removes it on the next falling edge, then samples the outputs at that falling edge, half a period after the edge that registered the result. The held requests are sampled again one full cycle later. The trace pulse is sampled one cycle later too, to confirm that it is a single cycle wide.

// File: rtl/dbg_trig_pkg.sv
`timescale 1ns/1ps
package dbg_trig_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int KINDS   = 7;           // longword, lower word, upper word, four lanes
    localparam int LVL_W   = 14;          // used bits of each half

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_L1HIT = 2'b10,
        ST_DONE  = 2'b11
    } trig_stat_t;

    typedef enum logic [2:0] {
        SEL_TDEF = 3'd0,
        SEL_LO   = 3'd1,
        SEL_HI   = 3'd2,
        SEL_DVAL = 3'd3,
        SEL_PCV  = 3'd4
    } cfg_sel_t;

    typedef struct packed {
        logic [31:0]       tdef;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [DATA_W-1:0] dval;
        logic [ADDR_W-1:0] pcv;
        trig_stat_t        stat;
        logic              trace;
    } trig_regs_t;
endpackage

// File: rtl/dbg_trig_lanes.sv
`timescale 1ns/1ps
module dbg_trig_lanes
    import dbg_trig_pkg::*;
(
    input  logic [1:0]         size,
    input  logic [1:0]         offs,
    output logic [DATA_W-1:0]  mask,
    output logic [KINDS-1:0]   kind
);
    localparam int LANE_BITS = 8;

    logic [LANES-1:0] lane_on;

    always_comb begin
        lane_on = '0;
        kind    = '0;
        unique case (size)
            2'd0: begin
                lane_on[offs] = 1'b1;
                kind[offs]    = 1'b1;
            end
            2'd1: begin
                if (offs[1]) begin
                    lane_on = 4'b1100;
                    kind[4] = 1'b1;
                end else begin
                    lane_on = 4'b0011;
                    kind[5] = 1'b1;
                end
            end
            default: begin
                lane_on = '1;
                kind[6] = 1'b1;
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask[g*LANE_BITS +: LANE_BITS] = {LANE_BITS{lane_on[g]}};
    end
endmodule

// File: rtl/dbg_trig_level.sv
`timescale 1ns/1ps
module dbg_trig_level
    import dbg_trig_pkg::*;
(
    input  logic [LVL_W-1:0]   cfg,
    input  logic               valid,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  data,
    input  logic [DATA_W-1:0]  mask,
    input  logic [KINDS-1:0]   kind,
    input  logic [ADDR_W-1:0]  lo,
    input  logic [ADDR_W-1:0]  hi,
    input  logic [DATA_W-1:0]  dval,
    input  logic [ADDR_W-1:0]  pcv,
    output logic               hit
);
    logic             lvl_en;
    logic [KINDS-1:0] den;
    logic             d_on, d_sel, d_eq, d_ok;
    logic             a_on, a_in, a_ok;
    logic             pc_ok, any_on;

    always_comb begin
        lvl_en = cfg[13];
        den    = cfg[12:6];

        d_on   = |den;
        d_sel  = |(den & kind);
        d_eq   = ((data ^ dval) & mask) == '0;
        d_ok   = !d_on || (d_sel && (d_eq ^ cfg[5]));

        a_on   = cfg[4] | cfg[3] | cfg[2];
        a_in   = cfg[3] ? ((addr >= lo) && (addr <= hi)) : (addr == lo);
        a_ok   = !a_on || (a_in ^ cfg[4]);

        pc_ok  = !cfg[1] || ((pc == pcv) ^ cfg[0]);

        any_on = d_on | a_on | cfg[1];
        hit    = valid && lvl_en && any_on && d_ok && a_ok && pc_ok;
    end
endmodule

// File: rtl/dbg_trig_unit.sv
`timescale 1ns/1ps
module dbg_trig_unit
    import dbg_trig_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_pc,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [1:0]         bus_size,
    input  logic [DATA_W-1:0]  bus_data,
    output logic [31:0]        tdef_rd,
    output logic [1:0]         trig_state,
    output logic               trace_pulse,
    output logic               halt_req,
    output logic               irq_req
);
    localparam int          NLVL      = 2;
    localparam logic [31:0] TDEF_KEEP = 32'hFFFF_3FFF;

    trig_regs_t         r_q, r_d;
    logic [DATA_W-1:0]  lane_mask;
    logic [KINDS-1:0]   acc_kind;
    logic [NLVL-1:0]    lvl_hit;
    logic               two_level;

    dbg_trig_lanes u_lanes (
        .size (bus_size),
        .offs (bus_addr[1:0]),
        .mask (lane_mask),
        .kind (acc_kind)
    );

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        dbg_trig_level u_level (
            .cfg   (r_q.tdef[16*g +: LVL_W]),
            .valid (bus_valid),
            .pc    (bus_pc),
            .addr  (bus_addr),
            .data  (bus_data),
            .mask  (lane_mask),
            .kind  (acc_kind),
            .lo    (r_q.lo),
            .hi    (r_q.hi),
            .dval  (r_q.dval),
            .pcv   (r_q.pcv),
            .hit   (lvl_hit[g])
        );
    end

    assign two_level = |r_q.tdef[29:16];

    always_comb begin
        r_d       = r_q;
        r_d.trace = 1'b0;

        unique case (r_q.stat)
            ST_ARMED: begin
                if (lvl_hit[0]) begin
                    if (two_level) begin
                        r_d.stat = ST_L1HIT;
                    end else begin
                        r_d.stat  = ST_DONE;
                        r_d.trace = 1'b1;
                    end
                end
            end
            ST_L1HIT: begin
                if (lvl_hit[1]) begin
                    r_d.stat  = ST_DONE;
                    r_d.trace = 1'b1;
                end
            end
            default: ;
        endcase

        if (cfg_we) begin
            unique case (cfg_sel)
                SEL_TDEF: begin
                    r_d.tdef  = cfg_wdata & TDEF_KEEP;
                    r_d.stat  = cfg_wdata[13] ? ST_ARMED : ST_IDLE;
                    r_d.trace = 1'b0;
                end
                SEL_LO:   r_d.lo   = cfg_wdata;
                SEL_HI:   r_d.hi   = cfg_wdata;
                SEL_DVAL: r_d.dval = cfg_wdata;
                SEL_PCV:  r_d.pcv  = cfg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{tdef: '0, lo: '0, hi: '0, dval: '0, pcv: '0,
                     stat: ST_IDLE, trace: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tdef_rd     = r_q.tdef;
    assign trig_state  = r_q.stat;
    assign trace_pulse = r_q.trace;
    assign halt_req    = (r_q.stat == ST_DONE) && (r_q.tdef[31:30] == 2'b01);
    assign irq_req     = (r_q.stat == ST_DONE) && (r_q.tdef[31:30] == 2'b10);
endmodule

// File: rtl/dbg_trig_unit_chk.sv
`timescale 1ns/1ps
module dbg_trig_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [2:0]  cfg_sel,
    input logic [31:0] cfg_wdata,
    input logic [31:0] tdef_rd,
    input logic [1:0]  trig_state,
    input logic        trace_pulse,
    input logic        halt_req,
    input logic        irq_req
);
    logic def_wr;
    assign def_wr = cfg_we && (cfg_sel == 3'd0);

    p_gap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tdef_rd[15:14] == 2'b00);

    p_one_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt_req && irq_req));

    p_trace_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trace_pulse |=> !trace_pulse);

    p_halt_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (tdef_rd[31:30] == 2'b01) && (trig_state == 2'b11));

    p_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tdef_rd[29] && !tdef_rd[13]) |-> (trig_state == 2'b00));

    p_def_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        def_wr |=> (trig_state == ($past(cfg_wdata[13]) ? 2'b01 : 2'b00)));

    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((halt_req || irq_req) && !def_wr) |=> $stable(trig_state) && $stable(halt_req) && $stable(irq_req));

    p_trace_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        trace_pulse |-> (trig_state == 2'b11));
endmodule

bind dbg_trig_unit dbg_trig_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .tdef_rd     (tdef_rd),
    .trig_state  (trig_state),
    .trace_pulse (trace_pulse),
    .halt_req    (halt_req),
    .irq_req     (irq_req)
);

// File: tb/dbg_trig_unit_tb.sv
`timescale 1ns/1ps
module dbg_trig_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_pc = '0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_data = '0;
    logic [31:0] tdef_rd;
    logic [1:0]  trig_state;
    logic        trace_pulse, halt_req, irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [31:0] DV  = 32'hA1B2_C3D4;
    localparam logic [31:0] LO  = 32'h0000_1000;
    localparam logic [31:0] HI  = 32'h0000_10FF;
    localparam logic [31:0] PCV = 32'h0000_0400;

    always #2 clk = ~clk;

    dbg_trig_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_pc(bus_pc),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_data(bus_data),
        .tdef_rd(tdef_rd), .trig_state(trig_state), .trace_pulse(trace_pulse),
        .halt_req(halt_req), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xfer(input logic v, input logic [31:0] pc, input logic [31:0] a,
                        input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = v; bus_pc = pc; bus_addr = a; bus_size = sz; bus_data = d;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    function automatic logic [31:0] ref_mask(input int sz, input int off);
        if (sz == 0) return 32'hFF << (8 * off);
        if (sz == 1) return (off >= 2) ? 32'hFFFF_0000 : 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic int ref_kind(input int sz, input int off);
        if (sz == 0) return off;
        if (sz == 1) return (off >= 2) ? 4 : 5;
        return 6;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] m;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 reset state", {30'd0, trig_state}, 32'd0);
        check("R1 reset definition", tdef_rd, 32'd0);
        check("R2 reset requests", {29'd0, trace_pulse, halt_req, irq_req}, 32'd0);

        // R1 readback
        wr(3'd0, 32'hFFFF_FFFF);
        check("R1 readback gap bits", tdef_rd, 32'hFFFF_3FFF);
        wr(3'd0, 32'h0000_0000);
        check("R4 definition write clears", {30'd0, trig_state}, 32'd0);

        wr(3'd1, LO); wr(3'd2, HI); wr(3'd3, DV); wr(3'd4, PCV);

        // R5/R6 sweep: size x offset x data enable
        for (int sz = 0; sz < 3; sz++) begin
            for (int off = 0; off < 4; off++) begin
                for (int en = 0; en < 7; en++) begin
                    m = ref_mask(sz, off);
                    e = (en == ref_kind(sz, off)) ? 32'd3 : 32'd1;
                    wr(3'd0, 32'h2000 | (32'h1 << (6 + en)));
                    check("R4 armed after write", {30'd0, trig_state}, 32'd1);
                    xfer(1'b1, 32'h0, 32'h100 + off, sz[1:0], DV ^ ~m);
                    check($sformatf("R5 sz%0d off%0d en%0d", sz, off, en), {30'd0, trig_state}, e);
                    wr(3'd0, 32'h2020 | (32'h1 << (6 + en)));
                    xfer(1'b1, 32'h0, 32'h100 + off, sz[1:0], DV ^ (m & 32'h0101_0101));
                    check($sformatf("R6 invert sz%0d off%0d en%0d", sz, off, en), {30'd0, trig_state}, e);
                    wr(3'd0, 32'h2020 | (32'h1 << (6 + en)));
                    xfer(1'b1, 32'h0, 32'h100 + off, sz[1:0], DV);
                    check($sformatf("R6 invert equal sz%0d off%0d en%0d", sz, off, en), {30'd0, trig_state}, 32'd1);
                end
            end
        end

        // R7 sweep: every address mode combination x boundary addresses
        for (int md = 1; md < 8; md++) begin
            for (int k = 0; k < 5; k++) begin
                logic [31:0] a;
                logic inr;
                case (k)
                    0: a = LO - 1;
                    1: a = LO;
                    2: a = LO + 1;
                    3: a = HI;
                    default: a = HI + 1;
                endcase
                inr = md[1] ? ((a >= LO) && (a <= HI)) : (a == LO);
                inr = inr ^ md[2];
                wr(3'd0, 32'h2000 | (md << 2));
                xfer(1'b1, 32'h0, a, 2'd2, 32'h0);
                check($sformatf("R7 mode%0d addr %h", md, a), {30'd0, trig_state}, inr ? 32'd3 : 32'd1);
            end
        end

        // R8 PC compare and invert
        for (int pi = 0; pi < 2; pi++) begin
            for (int k = 0; k < 2; k++) begin
                logic [31:0] pc;
                pc = (k == 0) ? PCV : PCV + 4;
                wr(3'd0, 32'h2002 | pi);
                xfer(1'b1, pc, 32'h0, 2'd2, 32'h0);
                check($sformatf("R8 inv%0d pc %h", pi, pc), {30'd0, trig_state},
                      (((pc == PCV) ? 1 : 0) ^ pi) != 0 ? 32'd3 : 32'd1);
            end
        end

        // R13 all enabled conditions must match; empty level never matches
        wr(3'd0, 32'h2000 | 32'h2 | 32'h4);
        xfer(1'b1, PCV, LO + 8, 2'd2, 32'h0);
        check("R13 PC match address miss", {30'd0, trig_state}, 32'd1);
        xfer(1'b1, PCV, LO, 2'd2, 32'h0);
        check("R13 both match", {30'd0, trig_state}, 32'd3);
        wr(3'd0, 32'h2000);
        xfer(1'b1, PCV, LO, 2'd2, DV);
        check("R13 no condition enabled", {30'd0, trig_state}, 32'd1);

        // R3 enables clear
        wr(3'd0, 32'h4000_0002);
        check("R3 disabled idle", {30'd0, trig_state}, 32'd0);
        xfer(1'b1, PCV, 32'h0, 2'd2, 32'h0);
        check("R3 disabled no fire", {29'd0, trig_state, halt_req}, 32'd0);

        // R12 invalid transfer ignored
        wr(3'd0, 32'h2002);
        xfer(1'b0, PCV, 32'h0, 2'd2, 32'h0);
        check("R12 invalid ignored", {29'd0, trig_state, trace_pulse}, {29'd0, 2'd1, 1'b0});

        // R2/R10/R11 responses, single-level
        for (int rc = 0; rc < 4; rc++) begin
            wr(3'd0, (rc << 30) | 32'h2002);
            xfer(1'b1, PCV, 32'h0, 2'd2, 32'h0);
            check($sformatf("R10 direct fire rc%0d", rc), {30'd0, trig_state}, 32'd3);
            check($sformatf("R2 response rc%0d", rc), {29'd0, trace_pulse, halt_req, irq_req},
                  {29'd0, 1'b1, rc == 1, rc == 2});
            @(negedge clk);
            check($sformatf("R11 hold rc%0d", rc), {29'd0, trace_pulse, halt_req, irq_req},
                  {29'd0, 1'b0, rc == 1, rc == 2});
            wr(3'd3, DV);
            check($sformatf("R11 other write keeps rc%0d", rc), {29'd0, trig_state, halt_req, irq_req},
                  {29'd0, 2'd3, rc == 1, rc == 2});
            wr(3'd0, 32'h0);
            check($sformatf("R11 release rc%0d", rc), {29'd0, trig_state, halt_req, irq_req}, 32'd0);
        end

        // R9 two-level sequencing: L1 = PC, L2 = address equal low bound, irq response
        wr(3'd1, 32'h0000_2000);
        wr(3'd0, 32'h8000_0000 | 32'h2000_0000 | 32'h0004_0000 | 32'h2002);
        xfer(1'b1, 32'h0, 32'h2000, 2'd2, 32'h0);
        check("R9 level 2 before level 1 ignored", {30'd0, trig_state}, 32'd1);
        xfer(1'b1, PCV, 32'h3000, 2'd2, 32'h0);
        check("R9 level 1 hit", {29'd0, trig_state, trace_pulse}, {29'd0, 2'd2, 1'b0});
        check("R9 no request after level 1", {30'd0, halt_req, irq_req}, 32'd0);
        xfer(1'b1, PCV, 32'h3000, 2'd2, 32'h0);
        check("R9 level 1 again waits", {30'd0, trig_state}, 32'd2);
        xfer(1'b1, 32'h0, 32'h2000, 2'd2, 32'h0);
        check("R9 level 2 completes", {28'd0, trig_state, trace_pulse, irq_req}, {28'd0, 2'd3, 1'b1, 1'b1});
        @(negedge clk);
        check("R2 trace single cycle", {31'd0, trace_pulse}, 32'd0);
        wr(3'd0, 32'h0);
        check("R4 clear after two-level", {30'd0, trig_state, irq_req}, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule